// File: doc/BRIEF.md
# Warp Barrier Synchronization Unit

This block holds groups of warps at numbered meeting points until enough of them have arrived. A warp that executes a barrier operation raises its arrival request for one cycle. The request carries a barrier number and the number of warps that must gather there, and both values come from the warp's own registers. The unit then stalls that warp. When the number of warps gathered at that barrier reaches the required number, every waiting warp is released in the same cycle and the barrier is emptied so that it can be used again.

Each barrier keeps its own member set and its own target count, so several barriers can fill up at the same time without affecting one another. A request that names a barrier that does not exist is rejected with an error pulse and is not counted. A warp scheduler reads the stall mask to decide which warps may issue. The per-warp release pulses tell the scheduler which warps resume in a given cycle.

Top module: `warp_barrier_unit`

## Requirements
- R1: During and after synchronous reset, `stall_mask`, `warp_release`, `bar_release` and `id_err` are all zero.
- R2: An accepted arrival that does not complete its barrier sets that warp's `stall_mask` bit from the cycle after the arrival edge, and the bit stays set until the barrier releases.
- R3: In the cycle after the arrival that brings a barrier's arrived-warp count up to its target, all of the barrier's members have their `stall_mask` bits clear. In that same cycle `warp_release` pulses for exactly those warps and `bar_release[id]` pulses, each for one cycle.
- R4: Arrivals at the same barrier in the same cycle are all counted in that cycle.
- R5: A target count of 0 or 1 releases the arriving warp at once: its stall bit never sets, and its `warp_release` bit and the `bar_release` bit pulse in the next cycle.
- R6: An arrival whose id is NUM_BARS or greater pulses `id_err` for that warp in the next cycle. The warp is not stalled and no barrier count changes.
- R7: The target count is taken from the first arrival at an empty barrier, and later counts are ignored until the barrier releases. If several warps reach an empty barrier in the same cycle, the count of the lowest-numbered of them is used.
- R8: Barriers are independent: arrivals and releases at one id leave the members and the target of every other id unchanged.
- R9: After a release, the same barrier id accepts a new group with a new target count.
- R10: An arrival request from a warp whose stall bit is already set is ignored.
- R11: Warp w's request fields sit at bits [w*ID_W +: ID_W] of `arr_id` and [w*CNT_W +: CNT_W] of `arr_count`. Bit w of every per-warp vector belongs to warp w, and bit b of `bar_release` belongs to barrier b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_valid | input | NUM_WARPS | One-cycle arrival request for each warp |
| arr_id | input | NUM_WARPS*ID_W | Barrier number for each warp |
| arr_count | input | NUM_WARPS*CNT_W | Target warp count for each warp |
| stall_mask | output | NUM_WARPS | Warps currently held at a barrier |
| warp_release | output | NUM_WARPS | One-cycle pulse for each warp that resumes |
| bar_release | output | NUM_BARS | One-cycle pulse for each barrier that opened |
| id_err | output | NUM_WARPS | One-cycle pulse for each rejected out-of-range arrival |

## Verification
The bench builds the unit with four warps, four barriers, a 3-bit id field and a 4-bit count field. The 3-bit id lets out-of-range values 4 to 7 reach the error path. The 4-bit count can carry targets above the warp count, which exposes which count was latched. Four warps are enough for two barriers to fill up at the same time, for three-way arrivals in a single cycle, and for re-arrival by a stalled warp while the other warps are still outside.

// File: rtl/warp_barrier_pkg.sv
package warp_barrier_pkg;

    localparam int MAX_WARPS = 32;

    typedef logic [MAX_WARPS-1:0] wmask_t;

    // isolate lowest set bit of a warp mask
    function automatic wmask_t lowest_set(input wmask_t v);
        wmask_t r;
        r = '0;
        for (int i = MAX_WARPS - 1; i >= 0; i--) begin
            if (v[i]) r = wmask_t'(1) << i;
        end
        return r;
    endfunction

    function automatic int unsigned pop_warps(input wmask_t v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < MAX_WARPS; i++) n += int'(v[i]);
        return n;
    endfunction

    typedef struct packed {
        logic   fire;
        wmask_t rel;
    } slot_evt_t;

endpackage

// File: rtl/bar_arrival_decode.sv
module bar_arrival_decode
    import warp_barrier_pkg::*;
#(
    parameter int NUM_WARPS = 4,
    parameter int NUM_BARS  = 4,
    parameter int ID_W      = 3
) (
    input  logic [NUM_WARPS-1:0]          req_valid,
    input  logic [NUM_WARPS*ID_W-1:0]     req_id,
    input  logic [NUM_WARPS-1:0]          held,
    output logic [NUM_BARS*NUM_WARPS-1:0] hit_flat,
    output logic [NUM_WARPS-1:0]          bad_id
);

    always_comb begin
        hit_flat = '0;
        bad_id   = '0;
        for (int w = 0; w < NUM_WARPS; w++) begin
            if (req_valid[w] && !held[w]) begin
                if (int'(req_id[w*ID_W +: ID_W]) < NUM_BARS) begin
                    for (int b = 0; b < NUM_BARS; b++) begin
                        if (int'(req_id[w*ID_W +: ID_W]) == b)
                            hit_flat[b*NUM_WARPS + w] = 1'b1;
                    end
                end else begin
                    bad_id[w] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bar_slot.sv
module bar_slot
    import warp_barrier_pkg::*;
#(
    parameter int NUM_WARPS = 4,
    parameter int CNT_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_WARPS-1:0]       hit,
    input  logic [NUM_WARPS*CNT_W-1:0] cnt_flat,
    output logic [NUM_WARPS-1:0]       members_o,
    output logic                       fire_o,
    output logic [NUM_WARPS-1:0]       rel_o
);

    logic [NUM_WARPS-1:0] members_q;
    logic [CNT_W-1:0]     target_q;
    slot_evt_t            evt_q;

    logic [NUM_WARPS-1:0] joined;
    logic [CNT_W-1:0]     first_cnt;
    logic [CNT_W-1:0]     target_eff;
    wmask_t               first_hit;
    logic                 empty;
    logic                 fire;

    always_comb begin
        empty     = (members_q == '0);
        joined    = members_q | hit;
        first_hit = lowest_set(wmask_t'(hit));
        first_cnt = '0;
        for (int w = 0; w < NUM_WARPS; w++) begin
            if (first_hit[w]) first_cnt = cnt_flat[w*CNT_W +: CNT_W];
        end
        target_eff = empty ? first_cnt : target_q;
        fire = (|hit) && (pop_warps(wmask_t'(joined)) >= int'(target_eff));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            members_q <= '0;
            target_q  <= '0;
            evt_q     <= '0;
        end else begin
            evt_q.fire <= fire;
            evt_q.rel  <= fire ? wmask_t'(joined) : '0;
            members_q  <= fire ? '0 : joined;
            if (empty && (|hit)) target_q <= first_cnt;
        end
    end

    assign members_o = members_q;
    assign fire_o    = evt_q.fire;
    assign rel_o     = evt_q.rel[NUM_WARPS-1:0];

endmodule

// File: rtl/warp_barrier_unit.sv
module warp_barrier_unit
    import warp_barrier_pkg::*;
#(
    parameter int NUM_WARPS = 4,
    parameter int NUM_BARS  = 4,
    parameter int ID_W      = 3,
    parameter int CNT_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_WARPS-1:0]       arr_valid,
    input  logic [NUM_WARPS*ID_W-1:0]  arr_id,
    input  logic [NUM_WARPS*CNT_W-1:0] arr_count,
    output logic [NUM_WARPS-1:0]       stall_mask,
    output logic [NUM_WARPS-1:0]       warp_release,
    output logic [NUM_BARS-1:0]        bar_release,
    output logic [NUM_WARPS-1:0]       id_err
);

    localparam int HIT_W = NUM_BARS * NUM_WARPS;

    logic [HIT_W-1:0]     hit_flat;
    logic [HIT_W-1:0]     mem_flat;
    logic [HIT_W-1:0]     rel_flat;
    logic [NUM_WARPS-1:0] bad_id;
    logic [NUM_WARPS-1:0] err_q;

    bar_arrival_decode #(
        .NUM_WARPS(NUM_WARPS), .NUM_BARS(NUM_BARS), .ID_W(ID_W)
    ) i_decode (
        .req_valid(arr_valid),
        .req_id   (arr_id),
        .held     (stall_mask),
        .hit_flat (hit_flat),
        .bad_id   (bad_id)
    );

    for (genvar b = 0; b < NUM_BARS; b++) begin : g_slot
        bar_slot #(
            .NUM_WARPS(NUM_WARPS), .CNT_W(CNT_W)
        ) i_slot (
            .clk      (clk),
            .rst      (rst),
            .hit      (hit_flat[b*NUM_WARPS +: NUM_WARPS]),
            .cnt_flat (arr_count),
            .members_o(mem_flat[b*NUM_WARPS +: NUM_WARPS]),
            .fire_o   (bar_release[b]),
            .rel_o    (rel_flat[b*NUM_WARPS +: NUM_WARPS])
        );
    end

    always_comb begin
        stall_mask   = '0;
        warp_release = '0;
        for (int b = 0; b < NUM_BARS; b++) begin
            stall_mask   = stall_mask   | mem_flat[b*NUM_WARPS +: NUM_WARPS];
            warp_release = warp_release | rel_flat[b*NUM_WARPS +: NUM_WARPS];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= '0;
        else     err_q <= bad_id;
    end

    assign id_err = err_q;

endmodule

// File: rtl/warp_barrier_chk.sv
module warp_barrier_chk #(
    parameter int NUM_WARPS = 4,
    parameter int NUM_BARS  = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_WARPS-1:0] arr_valid,
    input logic [NUM_WARPS-1:0] stall_mask,
    input logic [NUM_WARPS-1:0] warp_release,
    input logic [NUM_BARS-1:0]  bar_release,
    input logic [NUM_WARPS-1:0] id_err
);

    AST_RELEASED_NOT_STALLED: assert property (@(posedge clk) disable iff (rst)
        (warp_release & stall_mask) == '0); // R3

    AST_REJECTED_NOT_STALLED: assert property (@(posedge clk) disable iff (rst)
        (id_err & stall_mask) == '0); // R6

    AST_WARP_REL_HAS_BAR_REL: assert property (@(posedge clk) disable iff (rst)
        (|warp_release) |-> (|bar_release)); // R3

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_w
        AST_STALL_NEEDS_ARRIVAL: assert property (@(posedge clk) disable iff (rst)
            $rose(stall_mask[w]) |-> $past(arr_valid[w])); // R2

        AST_STALL_ENDS_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
            $fell(stall_mask[w]) |-> warp_release[w]); // R3

        AST_ERR_NEEDS_ARRIVAL: assert property (@(posedge clk) disable iff (rst)
            id_err[w] |-> $past(arr_valid[w])); // R6
    end

endmodule

bind warp_barrier_unit warp_barrier_chk #(
    .NUM_WARPS(NUM_WARPS), .NUM_BARS(NUM_BARS)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .arr_valid   (arr_valid),
    .stall_mask  (stall_mask),
    .warp_release(warp_release),
    .bar_release (bar_release),
    .id_err      (id_err)
);

// File: tb/test_warp_barrier_unit.sv
module test_warp_barrier_unit;

    localparam int NW = 4;
    localparam int NB = 4;
    localparam int IW = 3;
    localparam int CW = 4;

    typedef struct {
        logic [NW-1:0] stall;
        logic [NW-1:0] wrel;
        logic [NB-1:0] brel;
        logic [NW-1:0] err;
        string         tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NW-1:0]    arr_valid = '0;
    logic [NW*IW-1:0] arr_id = '0;
    logic [NW*CW-1:0] arr_count = '0;
    logic [NW-1:0]    stall_mask;
    logic [NW-1:0]    warp_release;
    logic [NB-1:0]    bar_release;
    logic [NW-1:0]    id_err;

    int   total = 0;
    int   bad = 0;
    bit   done = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    warp_barrier_unit #(
        .NUM_WARPS(NW), .NUM_BARS(NB), .ID_W(IW), .CNT_W(CW)
    ) i_warp_barrier_unit (
        .clk(clk), .rst(rst), .arr_valid(arr_valid), .arr_id(arr_id),
        .arr_count(arr_count), .stall_mask(stall_mask),
        .warp_release(warp_release), .bar_release(bar_release), .id_err(id_err)
    );

    // driver: one cycle of requests plus the outputs expected after that edge
    task automatic step(input logic [NW-1:0] v, input logic [NW*IW-1:0] ids,
                        input logic [NW*CW-1:0] cnts,
                        input logic [NW-1:0] e_stall, input logic [NW-1:0] e_wrel,
                        input logic [NB-1:0] e_brel, input logic [NW-1:0] e_err,
                        input string tag);
        exp_t e;
        @(negedge clk);
        arr_valid = v;
        arr_id    = ids;
        arr_count = cnts;
        e.stall = e_stall; e.wrel = e_wrel; e.brel = e_brel; e.err = e_err; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input logic [NW-1:0] e_stall, input string tag);
        step('0, '0, '0, e_stall, '0, '0, '0, tag);
    endtask

    // monitor: compare after each edge, away from it
    always @(posedge clk) begin
        #1;
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (stall_mask !== e.stall || warp_release !== e.wrel ||
                bar_release !== e.brel || id_err !== e.err) begin
                bad++;
                $display("FAIL %s: got stall=%b wrel=%b brel=%b err=%b exp stall=%b wrel=%b brel=%b err=%b",
                         e.tag, stall_mask, warp_release, bar_release, id_err,
                         e.stall, e.wrel, e.brel, e.err);
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got hung run exp completion");
        finish_run();
    end

    // ids and counts are packed warp3..warp0 (R11)
    initial begin
        repeat (3) @(posedge clk);
        #1;
        total++;
        if (stall_mask !== '0 || warp_release !== '0 || bar_release !== '0 || id_err !== '0) begin
            bad++;
            $display("FAIL R1: got %b %b %b %b exp all zero", stall_mask, warp_release, bar_release, id_err);
        end
        @(negedge clk);
        rst = 1'b0;

        // R2 / R3: barrier 1, target 2
        step(4'b0001, {3'd0,3'd0,3'd0,3'd1}, {4'd0,4'd0,4'd0,4'd2}, 4'b0001, 4'b0000, 4'b0000, 4'b0000, "R2 first arrival stalls");
        idle(4'b0001, "R2 stall holds");
        step(4'b0010, {3'd0,3'd0,3'd1,3'd0}, {4'd0,4'd0,4'd2,4'd0}, 4'b0000, 4'b0011, 4'b0010, 4'b0000, "R3 release both");
        idle(4'b0000, "R3 pulse lasts one cycle");

        // R5: targets 1 and 0
        step(4'b0100, {3'd0,3'd0,3'd0,3'd0}, {4'd0,4'd1,4'd0,4'd0}, 4'b0000, 4'b0100, 4'b0001, 4'b0000, "R5 target one");
        step(4'b1000, {3'd2,3'd0,3'd0,3'd0}, {4'd0,4'd0,4'd0,4'd0}, 4'b0000, 4'b1000, 4'b0100, 4'b0000, "R5 target zero");

        // R6: out-of-range id
        step(4'b0010, {3'd0,3'd0,3'd5,3'd0}, {4'd0,4'd0,4'd2,4'd0}, 4'b0000, 4'b0000, 4'b0000, 4'b0010, "R6 id five rejected");
        idle(4'b0000, "R6 error pulse ends");

        // R4: three simultaneous arrivals complete target 3
        step(4'b0111, {3'd0,3'd3,3'd3,3'd3}, {4'd0,4'd3,4'd3,4'd3}, 4'b0000, 4'b0111, 4'b1000, 4'b0000, "R4 same-cycle arrivals");

        // R7: latched target ignores later counts
        step(4'b0001, {3'd0,3'd0,3'd0,3'd2}, {4'd0,4'd0,4'd0,4'd3}, 4'b0001, 4'b0000, 4'b0000, 4'b0000, "R7 latch target 3");
        step(4'b0010, {3'd0,3'd0,3'd2,3'd0}, {4'd0,4'd0,4'd2,4'd0}, 4'b0011, 4'b0000, 4'b0000, 4'b0000, "R7 later count 2 ignored");
        step(4'b0100, {3'd0,3'd2,3'd0,3'd0}, {4'd0,4'd9,4'd0,4'd0}, 4'b0000, 4'b0111, 4'b0100, 4'b0000, "R7 third arrival releases");

        // R8: two barriers interleaved
        step(4'b0001, {3'd0,3'd0,3'd0,3'd0}, {4'd0,4'd0,4'd0,4'd2}, 4'b0001, 4'b0000, 4'b0000, 4'b0000, "R8 bar0 arrival");
        step(4'b0010, {3'd0,3'd0,3'd1,3'd0}, {4'd0,4'd0,4'd2,4'd0}, 4'b0011, 4'b0000, 4'b0000, 4'b0000, "R8 bar1 arrival");
        step(4'b0100, {3'd0,3'd0,3'd0,3'd0}, {4'd0,4'd2,4'd0,4'd0}, 4'b0010, 4'b0101, 4'b0001, 4'b0000, "R8 bar0 opens only");
        step(4'b1000, {3'd1,3'd0,3'd0,3'd0}, {4'd2,4'd0,4'd0,4'd0}, 4'b0000, 4'b1010, 4'b0010, 4'b0000, "R8 bar1 opens");

        // R10: stalled warp re-arriving is ignored
        step(4'b0001, {3'd0,3'd0,3'd0,3'd3}, {4'd0,4'd0,4'd0,4'd2}, 4'b0001, 4'b0000, 4'b0000, 4'b0000, "R10 first arrival");
        step(4'b0001, {3'd0,3'd0,3'd0,3'd3}, {4'd0,4'd0,4'd0,4'd2}, 4'b0001, 4'b0000, 4'b0000, 4'b0000, "R10 repeat not counted");
        step(4'b0010, {3'd0,3'd0,3'd3,3'd0}, {4'd0,4'd0,4'd2,4'd0}, 4'b0000, 4'b0011, 4'b1000, 4'b0000, "R10 real second releases");

        // R9: reuse barrier 3 with a new target
        step(4'b0011, {3'd0,3'd0,3'd3,3'd3}, {4'd0,4'd0,4'd3,4'd3}, 4'b0011, 4'b0000, 4'b0000, 4'b0000, "R9 reuse target 3");
        step(4'b0100, {3'd0,3'd3,3'd0,3'd0}, {4'd0,4'd3,4'd0,4'd0}, 4'b0000, 4'b0111, 4'b1000, 4'b0000, "R9 reuse releases");

        // R7: simultaneous first arrivals, lowest warp's count wins
        step(4'b0110, {3'd0,3'd0,3'd0,3'd0}, {4'd0,4'd4,4'd2,4'd0}, 4'b0000, 4'b0110, 4'b0001, 4'b0000, "R7 lowest warp count");

        // R6: error while barrier pending leaves its count unchanged
        step(4'b0001, {3'd0,3'd0,3'd0,3'd1}, {4'd0,4'd0,4'd0,4'd2}, 4'b0001, 4'b0000, 4'b0000, 4'b0000, "R6 pending arrival");
        step(4'b0010, {3'd0,3'd0,3'd7,3'd0}, {4'd0,4'd0,4'd2,4'd0}, 4'b0001, 4'b0000, 4'b0000, 4'b0010, "R6 id seven rejected");
        idle(4'b0001, "R6 barrier still waiting");
        step(4'b0010, {3'd0,3'd0,3'd1,3'd0}, {4'd0,4'd0,4'd2,4'd0}, 4'b0000, 4'b0011, 4'b0010, 4'b0000, "R6 count unaffected");
        idle(4'b0000, "R1 quiet after sequence");

        @(negedge clk);
        arr_valid = '0;
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule